// File: doc/BRIEF.md
# Monochrome Bit-Blit Raster-Op Datapath

This block is the word datapath of a blitter for a frame store that keeps one bit per pixel in 16-bit memory words. The host hands it one request per word: a source word as read from memory, the destination word currently at the target location, and the target word address. The block picks the source data, aligns it to the destination bit position with a shifter that remembers the previous source word, and merges it with the destination through one of sixteen raster functions. A per-bit write mask then decides which bits of the merged word replace the old destination bits. One cycle later it issues a write strobe with the address, the finished word and the mask.

A small configuration port sets the operating mode, the alignment shift, the copy direction, the source selection, the raster function, its enable and the write mask. In bit-blit mode the shifter is live. A request flagged as a pre-read only primes the shifter and produces no write. This is needed when the first destination pixel sits to the left of the first source pixel in an ascending copy, or to the right of it in a descending copy. Vector and normal modes pass the source word through unshifted. Writing the normal-mode value empties the shifter. Rows hold 128 words (2048 pixels), of which 1280 by 1024 pixels are visible, so the default word address has 17 bits.

Top module: `mono_blit_datapath`

## Requirements
- R1: Config address 0 is the mode register. Bits [7:5] hold the mode: 3'b010 is vector, 3'b100 is bit-blit and 3'b111 is normal. Bits [4:0] hold the shift, which is used modulo 16. After reset the mode is normal with shift 0. `req_ready` is high exactly when the mode field holds one of the three known codes.
- R2: An accepted request (`req_valid` and `req_ready`) with `req_prime` low makes `wr_en` high in the next cycle, with `wr_addr` equal to the request address. In every other case `wr_en` is low in the next cycle.
- R3: Config address 2 bits [3:0] hold the raster code (reset value 3). With the raster enable set, the result bit for source bit s and destination bit d is code bit {~s,~d}. This gives 0 zero, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), A ~D, B S|~D, C ~S, D ~S|D, E ~(S&D), F ones.
- R4: Config address 1 bit 0 is the raster enable (reset 0). When it is clear, the result equals the aligned source and the raster code has no effect.
- R5: Config address 1 bits [3:2] select the source (reset 2'b11). 2'b00 forces all ones, 2'b01 copies bit 0 of `req_src` into all 16 bits, and 2'b11 or 2'b10 passes `req_src` unchanged.
- R6: In bit-blit mode with config address 1 bit 1 clear (ascending), the output word for shift n is bits [15:0] of {previous, current} shifted right by n.
- R7: In bit-blit mode with config address 1 bit 1 set (descending), the output word for shift n is bits [31:16] of {current, previous} shifted left by n.
- R8: Every request accepted in bit-blit mode, including one with `req_prime` set, stores its selected source word as the next "previous" word. A request with `req_prime` set never writes. Requests in vector or normal mode leave the stored word unchanged.
- R9: Config address 3 holds the active-high write mask (reset all ones). `wr_data` bits whose mask bit is 0 equal the request's destination bits, and `wr_mask` repeats the mask.
- R10: Writing the mode register with bits [7:5] = 3'b111 clears the stored previous word. If a request is accepted in the same cycle, the request is computed with the configuration in force before the write, and the clear still wins over that request's capture.
- R11: In vector and normal modes the selected source reaches the raster stage unshifted, whatever the shift field holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_data | input | 16 | Configuration write data |
| req_valid | input | 1 | Word request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_prime | input | 1 | Request only primes the shifter |
| req_src | input | 16 | Source word read from memory |
| req_dst | input | 16 | Current destination word |
| req_addr | input | 17 | Destination word address |
| wr_en | output | 1 | Write strobe to the frame store |
| wr_addr | output | 17 | Write word address |
| wr_data | output | 16 | Merged word to write |
| wr_mask | output | 16 | Per-bit write enable, 1 = bit written |

## Verification
A configuration write and a word request can land on the same clock edge. The sharpest case is a normal-mode write arriving while a bit-blit request is accepted, because that request wants to capture its source into the shifter while the mode write wants to empty it. The bench provokes this by driving both ports in one cycle after the shifter has been loaded with a known word. It then checks that the word written in that cycle still used bit-blit alignment with the old previous word. A later bit-blit request must see an all-zero previous word, which shows that the clear beat the capture.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam logic [2:0] MODE_VECTOR = 3'b010;
  localparam logic [2:0] MODE_BLIT   = 3'b100;
  localparam logic [2:0] MODE_NORMAL = 3'b111;

  localparam logic [1:0] CFG_MODE = 2'd0;
  localparam logic [1:0] CFG_CTRL = 2'd1;
  localparam logic [1:0] CFG_ROP  = 2'd2;
  localparam logic [1:0] CFG_MASK = 2'd3;

  localparam logic [1:0] SEL_ONES  = 2'b00;
  localparam logic [1:0] SEL_PIXEL = 2'b01;

  localparam int MODE_LSB = 5;
  localparam int ROP_W    = 4;

  function automatic logic mode_is_known(input logic [2:0] m);
    return (m == MODE_VECTOR) || (m == MODE_BLIT) || (m == MODE_NORMAL);
  endfunction

endpackage

// File: rtl/blit_cfg_regs.sv
module blit_cfg_regs
  import blit_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int SH_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_data,
  output logic [2:0]        mode,
  output logic [SH_W-1:0]   shift,
  output logic              rop_en,
  output logic              desc,
  output logic [1:0]        src_sel,
  output logic [ROP_W-1:0]  rop_code,
  output logic [WORD_W-1:0] wmask,
  output logic              normal_wr
);

  logic mode_wr;
  assign mode_wr   = cfg_wr && (cfg_addr == CFG_MODE);
  assign normal_wr = mode_wr && (cfg_data[MODE_LSB+2:MODE_LSB] == MODE_NORMAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_NORMAL;
      shift    <= '0;
      rop_en   <= 1'b0;
      desc     <= 1'b0;
      src_sel  <= 2'b11;
      rop_code <= ROP_W'(3);
      wmask    <= '1;
    end else if (cfg_wr) begin
      unique case (cfg_addr)
        CFG_MODE: begin
          mode  <= cfg_data[MODE_LSB+2:MODE_LSB];
          shift <= cfg_data[SH_W-1:0];
        end
        CFG_CTRL: begin
          rop_en  <= cfg_data[0];
          desc    <= cfg_data[1];
          src_sel <= cfg_data[3:2];
        end
        CFG_ROP:  rop_code <= cfg_data[ROP_W-1:0];
        default:  wmask    <= cfg_data;
      endcase
    end
  end

  // R1: a mode write lands in the mode register on the next edge
  assert_mode_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> mode == $past(cfg_data[MODE_LSB+2:MODE_LSB]));

endmodule

// File: rtl/blit_aligner.sv
module blit_aligner #(
  parameter int WORD_W = 16,
  localparam int SH_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              bypass,
  input  logic              desc,
  input  logic [SH_W-1:0]   shift,
  input  logic [WORD_W-1:0] cur,
  output logic [WORD_W-1:0] aligned
);

  logic [WORD_W-1:0] prev_q;

  function automatic logic [WORD_W-1:0] align_word(
    input logic [WORD_W-1:0] prev,
    input logic [WORD_W-1:0] now,
    input logic [SH_W-1:0]   sh,
    input logic              down
  );
    logic [2*WORD_W-1:0] cat;
    if (!down) begin
      cat = {prev, now} >> sh;
      return cat[WORD_W-1:0];
    end
    cat = {now, prev} << sh;
    return cat[2*WORD_W-1:WORD_W];
  endfunction

  assign aligned = bypass ? cur : align_word(prev_q, cur, shift, desc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (clear)   prev_q <= '0;
    else if (capture) prev_q <= cur;
  end

  // R10: a normal-mode write empties the previous word, even against a capture
  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> prev_q == '0);

  // R8: bit-blit capture stores the current source word
  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !clear) |=> prev_q == $past(cur));

  // R8: outside capture the previous word holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clear) |=> $stable(prev_q));

endmodule

// File: rtl/blit_rop_stage.sv
module blit_rop_stage
  import blit_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] s,
  input  logic [WORD_W-1:0] d,
  input  logic              rop_en,
  input  logic [ROP_W-1:0]  rop_code,
  input  logic [WORD_W-1:0] mask,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] wr_mask
);

  function automatic logic [WORD_W-1:0] raster(
    input logic [ROP_W-1:0]  code,
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] b
  );
    unique case (code)
      4'h0: return '0;
      4'h1: return a & b;
      4'h2: return a & ~b;
      4'h3: return a;
      4'h4: return ~a & b;
      4'h5: return b;
      4'h6: return a ^ b;
      4'h7: return a | b;
      4'h8: return ~(a | b);
      4'h9: return ~(a ^ b);
      4'hA: return ~b;
      4'hB: return a | ~b;
      4'hC: return ~a;
      4'hD: return ~a | b;
      4'hE: return ~(a & b);
      default: return '1;
    endcase
  endfunction

  logic [WORD_W-1:0] merged;
  assign merged = rop_en ? raster(rop_code, s, d) : s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_mask <= '0;
    end else begin
      wr_en <= fire;
      if (fire) begin
        wr_addr <= addr;
        wr_data <= (merged & mask) | (d & ~mask);
        wr_mask <= mask;
      end
    end
  end

  // R2: a firing request produces the strobe one cycle later
  assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> wr_en && wr_addr == $past(addr));

  // R2: no strobe without a firing request
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !wr_en);

  // R9: unmasked bits keep the destination value
  assert_mask_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((wr_data ^ $past(d)) & ~wr_mask) == '0);

endmodule

// File: rtl/mono_blit_datapath.sv
module mono_blit_datapath
  import blit_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_prime,
  input  logic [WORD_W-1:0] req_src,
  input  logic [WORD_W-1:0] req_dst,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] wr_mask
);

  localparam int SH_W = $clog2(WORD_W);

  logic [2:0]        mode;
  logic [SH_W-1:0]   shift;
  logic              rop_en, desc, normal_wr;
  logic [1:0]        src_sel;
  logic [ROP_W-1:0]  rop_code;
  logic [WORD_W-1:0] wmask;

  logic              accept, in_blit, capture, fire;
  logic [WORD_W-1:0] picked, aligned;

  function automatic logic [WORD_W-1:0] pick_source(
    input logic [1:0]        sel,
    input logic [WORD_W-1:0] raw
  );
    if (sel == SEL_ONES)  return '1;
    if (sel == SEL_PIXEL) return {WORD_W{raw[0]}};
    return raw;
  endfunction

  blit_cfg_regs #(.WORD_W(WORD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .mode(mode), .shift(shift), .rop_en(rop_en),
    .desc(desc), .src_sel(src_sel), .rop_code(rop_code), .wmask(wmask),
    .normal_wr(normal_wr)
  );

  assign req_ready = mode_is_known(mode);
  assign accept    = req_valid && req_ready;
  assign in_blit   = (mode == MODE_BLIT);
  assign capture   = accept && in_blit;
  assign fire      = accept && !req_prime;
  assign picked    = pick_source(src_sel, req_src);

  blit_aligner #(.WORD_W(WORD_W)) u_align (
    .clk(clk), .rst_n(rst_n), .clear(normal_wr), .capture(capture),
    .bypass(!in_blit), .desc(desc), .shift(shift), .cur(picked),
    .aligned(aligned)
  );

  blit_rop_stage #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rop (
    .clk(clk), .rst_n(rst_n), .fire(fire), .addr(req_addr), .s(aligned),
    .d(req_dst), .rop_en(rop_en), .rop_code(rop_code), .mask(wmask),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask)
  );

  // R8: a priming request never reaches the write strobe
  assert_prime_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_prime) |=> !wr_en);

  // R11: outside bit-blit the aligner output is the picked source
  assert_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_blit |-> aligned == picked);

endmodule

// File: tb/mono_blit_datapath_test.sv
module mono_blit_datapath_test;

  localparam int W = 16;
  localparam int A = 17;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [W-1:0] cfg_data = '0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_prime = 1'b0;
  logic [W-1:0] req_src = '0;
  logic [W-1:0] req_dst = '0;
  logic [A-1:0] req_addr = '0;
  logic         wr_en;
  logic [A-1:0] wr_addr;
  logic [W-1:0] wr_data;
  logic [W-1:0] wr_mask;

  always #2 clk = ~clk;

  mono_blit_datapath #(.WORD_W(W), .ADDR_W(A)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_prime(req_prime), .req_src(req_src), .req_dst(req_dst),
    .req_addr(req_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask)
  );

  int total = 0;
  int bad = 0;

  // scoreboard
  logic [A+2*W-1:0] exp_q[$];
  string            tag_q[$];

  // bench model of the configuration
  logic [2:0] m_mode = 3'b111;
  int         m_shift = 0;
  logic       m_ropen = 1'b0, m_desc = 1'b0;
  logic [1:0] m_sel = 2'b11;
  logic [3:0] m_rop = 4'h3;
  logic [W-1:0] m_mask = '1;
  logic [W-1:0] m_prev = '0;

  function automatic logic [W-1:0] m_source(logic [1:0] sel, logic [W-1:0] raw);
    case (sel)
      2'b00:   return 16'hFFFF;
      2'b01:   return raw[0] ? 16'hFFFF : 16'h0000;
      default: return raw;
    endcase
  endfunction

  function automatic logic [W-1:0] m_shifted(logic [W-1:0] p, logic [W-1:0] c,
                                             int sh, logic down);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int k;
      if (!down) begin
        k = i + sh;
        r[i] = (k < W) ? c[k] : p[k-W];
      end else begin
        k = i + W - sh;
        r[i] = (k >= W) ? c[k-W] : p[k];
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] m_raster(logic [3:0] code, logic [W-1:0] s,
                                            logic [W-1:0] d);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = code[{~s[i], ~d[i]}];
    return r;
  endfunction

  function automatic logic known(logic [2:0] m);
    return m == 3'b010 || m == 3'b100 || m == 3'b111;
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  // one cycle that may carry a request and/or a configuration write
  task automatic cycle(logic do_req, logic [W-1:0] src, logic [W-1:0] dst,
                       logic [A-1:0] addr, logic prime,
                       logic do_cfg, logic [1:0] ca, logic [W-1:0] cd,
                       string req);
    @(posedge clk); #1;
    if (do_req && known(m_mode)) begin
      logic [W-1:0] s, al, mg;
      s  = m_source(m_sel, src);
      al = (m_mode == 3'b100) ? m_shifted(m_prev, s, m_shift, m_desc) : s;
      mg = m_ropen ? m_raster(m_rop, al, dst) : al;
      if (!prime) begin
        exp_q.push_back({addr, (mg & m_mask) | (dst & ~m_mask), m_mask});
        tag_q.push_back(req);
      end
      if (m_mode == 3'b100) m_prev = s;
    end
    if (do_cfg) begin
      case (ca)
        2'd0: begin
          m_mode = cd[7:5];
          m_shift = int'(cd[3:0]);
          if (cd[7:5] == 3'b111) m_prev = '0;
        end
        2'd1: begin m_ropen = cd[0]; m_desc = cd[1]; m_sel = cd[3:2]; end
        2'd2: m_rop = cd[3:0];
        default: m_mask = cd;
      endcase
    end
    req_valid = do_req; req_src = src; req_dst = dst; req_addr = addr;
    req_prime = prime;
    cfg_wr = do_cfg; cfg_addr = ca; cfg_data = cd;
    @(posedge clk); #1;
    req_valid = 1'b0; req_prime = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic cfg(logic [1:0] ca, logic [W-1:0] cd);
    cycle(1'b0, '0, '0, '0, 1'b0, 1'b1, ca, cd, "cfg");
  endtask

  task automatic send(logic [W-1:0] src, logic [W-1:0] dst, logic [A-1:0] addr,
                      logic prime, string req);
    cycle(1'b1, src, dst, addr, prime, 1'b0, 2'd0, '0, req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2: unexpected write addr %h data %h, expected none",
                 wr_addr, wr_data);
      end else begin
        logic [A+2*W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if ({wr_addr, wr_data, wr_mask} !== e) begin
          bad++;
          $display("FAIL %s: got addr %h data %h mask %h expected addr %h data %h mask %h",
                   t, wr_addr, wr_data, wr_mask, e[A+2*W-1:2*W], e[2*W-1:W], e[W-1:0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {15'b0, req_ready}, 16'h1);
    check("R2 idle after reset", {15'b0, wr_en}, 16'h0);

    // R11/R4: normal mode passes source; raster code ignored while disabled
    cfg(2'd0, 16'h00E9);          // normal, shift 9 ignored
    cfg(2'd2, 16'h000C);
    send(16'h1234, 16'hFFFF, 17'h00010, 1'b0, "R11 normal unshifted");
    send(16'hBEEF, 16'h0000, 17'h1FFFF, 1'b0, "R4 copy with rop off");

    // R3: all sixteen raster functions
    cfg(2'd1, 16'h000D);          // rop on, asc, plane
    for (int c = 0; c < 16; c++) begin
      cfg(2'd2, W'(c));
      send(16'hA5C3, 16'h0FF0, A'(c), 1'b0, "R3 raster table");
    end
    cfg(2'd2, 16'h0003);

    // R5: source select
    cfg(2'd1, 16'h0001);          // sel ones
    send(16'h0000, 16'h1111, 17'h20, 1'b0, "R5 all ones");
    cfg(2'd1, 16'h0005);          // sel pixel
    send(16'h0001, 16'h0000, 17'h21, 1'b0, "R5 pixel one");
    send(16'hFFFE, 16'h0000, 17'h22, 1'b0, "R5 pixel zero");
    cfg(2'd1, 16'h0009);          // sel 10 acts as plane
    send(16'h5A5A, 16'h0000, 17'h23, 1'b0, "R5 plane alt code");

    // R9: partial mask
    cfg(2'd1, 16'h000C);
    cfg(2'd3, 16'h00F0);
    send(16'hFFFF, 16'h1234, 17'h30, 1'b0, "R9 masked merge");
    send(16'h0000, 16'hFFFF, 17'h31, 1'b0, "R9 masked merge clear");
    cfg(2'd3, 16'hFFFF);

    // R6/R8: ascending blit with prime, shift 12
    cfg(2'd0, 16'h008C);
    send(16'h1357, 16'h0000, 17'h40, 1'b1, "R8 prime");
    send(16'h9BDF, 16'h0000, 17'h41, 1'b0, "R6 ascending word 1");
    send(16'hC3A5, 16'h0000, 17'h42, 1'b0, "R6 ascending word 2");
    cfg(2'd0, 16'h0083);          // shift 3, previous kept
    send(16'h0F0F, 16'h0000, 17'h43, 1'b0, "R6 ascending shift 3");

    // R8/R11: vector mode leaves the previous word untouched
    cfg(2'd0, 16'h0045);
    send(16'h7777, 16'h0000, 17'h50, 1'b0, "R11 vector unshifted");
    send(16'h6666, 16'h0000, 17'h51, 1'b1, "R8 vector prime silent");
    cfg(2'd0, 16'h0085);
    send(16'h8001, 16'h0000, 17'h52, 1'b0, "R8 previous kept across vector");

    // R7: descending blit, shift 5
    cfg(2'd1, 16'h000E);
    send(16'hF00F, 16'h0000, 17'h60, 1'b1, "R8 prime descending");
    send(16'h1248, 16'h0000, 17'h5F, 1'b0, "R7 descending word 1");
    send(16'hAAAA, 16'h0000, 17'h5E, 1'b0, "R7 descending word 2");
    cfg(2'd1, 16'h000C);

    // R10: normal-mode write in the same cycle as a blit request
    cfg(2'd0, 16'h0084);
    send(16'hCAFE, 16'h0000, 17'h70, 1'b1, "R8 prime before clear");
    cycle(1'b1, 16'h1234, 16'h0000, 17'h71, 1'b0, 1'b1, 2'd0, 16'h00E0,
          "R10 old config used with clear");
    cfg(2'd0, 16'h0084);
    send(16'hFFFF, 16'h0000, 17'h72, 1'b0, "R10 previous cleared");

    // R10: raster change in the same cycle uses the old code
    cfg(2'd1, 16'h000D);
    cycle(1'b1, 16'h00FF, 16'h0F0F, 17'h73, 1'b0, 1'b1, 2'd2, 16'h0006,
          "R10 old rop used");
    send(16'h00FF, 16'h0F0F, 17'h74, 1'b0, "R10 new rop applied");

    // R1: unknown mode refuses requests
    cfg(2'd0, 16'h0000);
    @(negedge clk);
    check("R1 ready low on unknown mode", {15'b0, req_ready}, 16'h0);
    send(16'h1111, 16'h2222, 17'h80, 1'b0, "R1 refused");
    cfg(2'd0, 16'h00E0);
    @(negedge clk);
    check("R1 ready back in normal mode", {15'b0, req_ready}, 16'h1);

    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2 every expected write seen", 16'(exp_q.size()), 16'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule